// File: doc/BRIEF.md
# Parity Memory Write Gate

This block sits between a local bus and a wide local memory and protects the stored words with one parity bit per data byte. Every write presents the data byte lanes to the memory together with freshly computed odd parity bits, which are stored beside the data. Every read hands the memory word back to the bus. When the parity control input is high, the block also re-checks the returned parity on the bytes the read asked for and raises a one-cycle error pulse on any mismatch.

While parity is enabled, only whole 32-bit or 64-bit writes reach the memory. A write whose byte enables leave any aligned 4-byte lane partly covered (8-, 16- or 24-bit transfers) is refused: no memory byte changes. Each refusal is reported as a one-cycle write-inhibited pulse. Latching these pulses into a status register is left to the surrounding logic. The memory is a plain synchronous RAM with one cycle of read latency, driven through per-byte write enables.

Top module: `par_wr_gate`

## Requirements
- R1: For every write, each bit of `mem_wpar_o` is the odd parity of its data byte. The bit is 1 when that byte holds an even number of ones, so that byte and bit together hold an odd count. `mem_wdata_o` equals `wdata_i`.
- R2: With `par_en_i` low, a write with nonzero `be_i` drives `mem_we_o` equal to `be_i`, and the memory takes exactly those bytes.
- R3: With `par_en_i` high, a write is full-shape when each aligned group of 4 byte enables (bits 3:0, bits 7:4) is all ones or all zeros and at least one group is all ones. A full-shape write drives `mem_we_o` equal to `be_i`.
- R4: With `par_en_i` high, a write with nonzero `be_i` that is not full-shape drives `mem_we_o` to zero and leaves the memory word unchanged.
- R5: `wr_inh_o` is high for exactly the one cycle after each write refused under R4, and is low at all other times.
- R6: `rvalid_o` is high in the cycle after `rd_i`, and in that cycle `rdata_o` carries the addressed memory word.
- R7: The value of `par_en_i` is taken in the read strobe cycle. If that value is high and any byte selected by the read's `be_i` fails odd parity, `par_err_o` pulses in the cycle after `rvalid_o`.
- R8: No error pulse is raised when `par_en_i` was low at the read strobe, or when the parity failures lie only in bytes the read did not select.
- R9: A write with `be_i` all zero changes no memory byte and raises no `wr_inh_o`.
- R10: While reset is held and right after it is released, `rvalid_o`, `par_err_o`, `wr_inh_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_en_i | input | 1 | Parity mode enable |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (never with wr_i) |
| addr_i | input | ADDR_W | Word address |
| be_i | input | DATA_W/8 | Byte enables |
| wdata_i | input | DATA_W | Write data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Memory read enable |
| mem_we_o | output | DATA_W/8 | Memory per-byte write enables |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_wpar_o | output | DATA_W/8 | Parity bits to store |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after mem_rd_o |
| mem_rpar_i | input | DATA_W/8 | Stored parity bits, same timing as mem_rdata_i |
| rdata_o | output | DATA_W | Read data to the bus |
| rvalid_o | output | 1 | Read data valid |
| par_err_o | output | 1 | Parity error pulse |
| wr_inh_o | output | 1 | Write-inhibited pulse |

## Verification
The parity error pulse from a read and the write-inhibited pulse from a refused write can fall in the same cycle. The error pulse comes two cycles after its read strobe and the inhibit pulse one cycle after its write strobe. The bench issues a read of a word with a corrupted parity bit and follows it at once with a narrow write while parity is enabled. It then samples both pulse outputs in the same cycle and expects each one high. Around that case, every byte-enable pattern is swept for writes under both modes, and every corruption mask is swept against several read enable patterns. The expected results come from byte arithmetic in the bench.

// File: rtl/par_gate_pkg.sv
package par_gate_pkg;
  localparam int BYTE_W     = 8;
  localparam int LANE_BYTES = 4;

  // odd parity: stored bit makes the 9-bit group hold an odd count of ones
  function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/par_gen.sv
module par_gen
  import par_gate_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] data_i,
  output logic [NBYTES-1:0]        par_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign par_o[b] = odd_bit(data_i[b*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/wr_gate.sv
module wr_gate
  import par_gate_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_en_i,
  input  logic              wr_i,
  input  logic [NBYTES-1:0] be_i,
  output logic [NBYTES-1:0] mem_we_o,
  output logic              wr_inh_o
);
  localparam int NLANES = NBYTES / LANE_BYTES;

  logic [NLANES-1:0] lane_full, lane_empty;
  logic shape_ok, any_be, narrow, allow;
  logic inh_q;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign lane_full[l]  = &be_i[l*LANE_BYTES +: LANE_BYTES];
    assign lane_empty[l] = ~|be_i[l*LANE_BYTES +: LANE_BYTES];
  end

  assign any_be   = |be_i;
  assign shape_ok = (&(lane_full | lane_empty)) & (|lane_full);
  assign narrow   = any_be & ~shape_ok;
  assign allow    = wr_i & any_be & (~par_en_i | shape_ok);
  assign mem_we_o = allow ? be_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inh_q <= 1'b0;
    else         inh_q <= wr_i & par_en_i & narrow;
  end
  assign wr_inh_o = inh_q;

  p_inh_after_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inh_o |-> $past(wr_i && par_en_i));
  p_inh_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inh_o |-> $past(mem_we_o) == '0);
  p_we_within_be_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o & ~be_i) == '0);
  p_we_needs_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> mem_we_o == '0);
endmodule

// File: rtl/rd_check.sv
module rd_check
  import par_gate_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     par_en_i,
  input  logic                     rd_i,
  input  logic [NBYTES-1:0]        be_i,
  input  logic [NBYTES*BYTE_W-1:0] mem_rdata_i,
  input  logic [NBYTES-1:0]        mem_rpar_i,
  output logic                     rvalid_o,
  output logic                     par_err_o
);
  logic              vld_q, en_q, err_q;
  logic [NBYTES-1:0] be_q, bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      en_q  <= 1'b0;
      be_q  <= '0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) begin
        en_q <= par_en_i;
        be_q <= be_i;
      end
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_chk
    // even count over byte plus stored bit means corruption
    assign bad[b] = ~^{mem_rpar_i[b], mem_rdata_i[b*BYTE_W +: BYTE_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= vld_q & en_q & (|(bad & be_q));
  end

  assign rvalid_o  = vld_q;
  assign par_err_o = err_q;

  p_valid_follows_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  p_err_after_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> $past(rvalid_o));
  p_err_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> $past(par_en_i, 2));
endmodule

// File: rtl/par_wr_gate.sv
module par_wr_gate
  import par_gate_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 par_en_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_rd_o,
  output logic [DATA_W/8-1:0]  mem_we_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  output logic [DATA_W/8-1:0]  mem_wpar_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  input  logic [DATA_W/8-1:0]  mem_rpar_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  output logic                 par_err_o,
  output logic                 wr_inh_o
);
  localparam int NBYTES = DATA_W / BYTE_W;

  assign mem_addr_o  = addr_i;
  assign mem_rd_o    = rd_i;
  assign mem_wdata_o = wdata_i;
  assign rdata_o     = mem_rdata_i;

  par_gen #(.NBYTES(NBYTES)) u_gen (
    .data_i (wdata_i),
    .par_o  (mem_wpar_o)
  );

  wr_gate #(.NBYTES(NBYTES)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .par_en_i (par_en_i),
    .wr_i     (wr_i),
    .be_i     (be_i),
    .mem_we_o (mem_we_o),
    .wr_inh_o (wr_inh_o)
  );

  rd_check #(.NBYTES(NBYTES)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .par_en_i    (par_en_i),
    .rd_i        (rd_i),
    .be_i        (be_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_rpar_i  (mem_rpar_i),
    .rvalid_o    (rvalid_o),
    .par_err_o   (par_err_o)
  );

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
endmodule

// File: tb/par_wr_gate_tb.sv
module par_wr_gate_tb_top;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          par_en = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] be = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] flip = '0;

  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [NB-1:0] mem_we, mem_wpar, mem_rpar;
  logic [DW-1:0] mem_wdata, mem_rdata, rdata;
  logic          rvalid, par_err, wr_inh;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  par_wr_gate #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .par_en_i(par_en), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_wpar_o(mem_wpar),
    .mem_rdata_i(mem_rdata), .mem_rpar_i(mem_rpar),
    .rdata_o(rdata), .rvalid_o(rvalid), .par_err_o(par_err), .wr_inh_o(wr_inh)
  );

  // memory model: synchronous, one cycle read latency; flip corrupts returned parity
  logic [DW-1:0] mem_d [2**AW];
  logic [NB-1:0] mem_p [2**AW];
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (mem_we[b]) begin
        mem_d[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        mem_p[mem_addr][b]        <= mem_wpar[b];
      end
    if (mem_rd) begin
      mem_rdata <= mem_d[mem_addr];
      mem_rpar  <= mem_p[mem_addr] ^ flip;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_par(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += int'(d[b*8+k]);
      p[b] = (ones % 2 == 0);
    end
    return p;
  endfunction

  function automatic bit full_shape(input logic [NB-1:0] e);
    bit any_full = 0;
    for (int l = 0; l < NB/4; l++) begin
      int cnt = 0;
      for (int k = 0; k < 4; k++) cnt += int'(e[l*4+k]);
      if (cnt == 4) any_full = 1;
      else if (cnt != 0) return 0;
    end
    return any_full;
  endfunction

  task automatic do_write(input logic en, input logic [AW-1:0] a, input logic [NB-1:0] e,
                          input logic [DW-1:0] d, input bit check);
    bit ok, inh;
    ok  = (e != 0) && (!en || full_shape(e));
    inh = en && (e != 0) && !full_shape(e);
    @(negedge clk);
    par_en = en; wr = 1'b1; addr = a; be = e; wdata = d;
    #5;
    if (check) begin
      chk(e == 0 ? "R9 we" : (!en ? "R2 we" : (ok ? "R3 we" : "R4 we")),
          DW'(mem_we), ok ? DW'(e) : '0);
      chk("R1 parity", DW'(mem_wpar), DW'(exp_par(d)));
      chk("R1 data", mem_wdata, d);
    end
    @(negedge clk);
    wr = 1'b0; be = '0;
    #5;
    if (check) chk(e == 0 ? "R9 inh" : "R5 inh", DW'(wr_inh), DW'(inh));
  endtask

  task automatic do_read(input logic en, input logic [AW-1:0] a, input logic [NB-1:0] e,
                         input logic [NB-1:0] f, input logic [DW-1:0] exp_d, input logic exp_err,
                         input string tag);
    @(negedge clk);
    par_en = en; rd = 1'b1; addr = a; be = e; flip = f;
    @(negedge clk);
    rd = 1'b0; be = '0; par_en = ~en;   // enable taken at strobe only
    #5;
    chk("R6 rvalid", DW'(rvalid), 64'd1);
    chk("R6 rdata", rdata, exp_d);
    @(negedge clk);
    #5;
    chk(tag, DW'(par_err), DW'(exp_err));
    flip = '0;
  endtask

  task automatic run_all();
    logic [DW-1:0] base, nd, expw;
    logic [NB-1:0] rbe [6];
    rbe = '{8'hFF, 8'h0F, 8'hF0, 8'h01, 8'h80, 8'h3C};

    #5;
    chk("R10 rvalid", DW'(rvalid), '0);
    chk("R10 par_err", DW'(par_err), '0);
    chk("R10 wr_inh", DW'(wr_inh), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10 after", DW'({rvalid, par_err, wr_inh, |mem_we}), '0);

    // write sweep: every byte-enable pattern in both modes
    for (int en = 0; en < 2; en++)
      for (int e = 0; e < 256; e++) begin
        base = 64'h0123_4567_89AB_CDEF ^ DW'(e * 64'h0101_0101);
        nd   = {8{8'(e)}} ^ 64'hA5C3_5A3C_F00F_1E96;
        do_write(1'b0, AW'(e), 8'hFF, base, 0);
        do_write(1'(en), AW'(e), 8'(e), nd, 1);
        expw = base;
        if (e != 0 && (en == 0 || full_shape(8'(e))))
          for (int b = 0; b < NB; b++) if (e[b]) expw[b*8 +: 8] = nd[b*8 +: 8];
        do_read(1'b1, AW'(e), 8'hFF, '0, expw, 1'b0,
                (en == 1 && !full_shape(8'(e)) && e != 0) ? "R4 mem kept" : "R2 R3 mem");
      end

    // read sweep: every corruption mask against several read enables
    do_write(1'b1, 4'd5, 8'hFF, 64'h1357_9BDF_2468_ACE0, 0);
    for (int en = 0; en < 2; en++)
      for (int f = 0; f < 256; f++)
        for (int k = 0; k < 6; k++)
          do_read(1'(en), 4'd5, rbe[k], 8'(f), 64'h1357_9BDF_2468_ACE0,
                  (en == 1) && ((8'(f) & rbe[k]) != 0),
                  (en == 1) ? (((8'(f) & rbe[k]) != 0) ? "R7 err" : "R8 masked")
                            : "R8 disabled");

    // collision: error pulse and inhibit pulse in the same cycle
    @(negedge clk);
    par_en = 1'b1; rd = 1'b1; addr = 4'd5; be = 8'hFF; flip = 8'h01;
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; be = 8'h01; wdata = '0;
    @(negedge clk);
    wr = 1'b0; be = '0; flip = '0;
    #5;
    chk("R7 collide err", DW'(par_err), 64'd1);
    chk("R5 collide inh", DW'(wr_inh), 64'd1);
    @(negedge clk);
    #5;
    chk("R5 single pulse", DW'({par_err, wr_inh}), '0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule